// File: doc/BRIEF.md
# Full/Empty Tagged Word Memory

A word-addressed storage block where each word carries one tag bit recording whether it currently holds a produced value (full) or is waiting for one (empty). Plain loads and stores read and write data without looking at the tag. Synchronizing stores wait until the word is empty, then deposit data and mark it full. Synchronizing loads wait until the word is full, then return the data and mark it empty. Together these give a one-word producer/consumer mailbox at every address.

Each request port uses a valid/ready handshake. A request that must wait keeps its ready low until the tag allows it. The tag test, the tag update and the data access all happen in the cycle the request is accepted, so no other request can slip in between. A separate tag command lets software force a word's tag either way. With two ports, a waiting request on one port never holds up the other port, and a same-word collision is settled in favour of port 0.

Top module: `fe_sync_mem`

## Requirements
- R1: After reset every tag is empty, so a synchronizing load (op code 2) to any address is held with ready low and a synchronizing store (op code 3) is ready.
- R2: A plain store (op code 1) writes data and a plain load (op code 0) returns it. Neither one waits on the tag or changes it.
- R3: A synchronizing store is held while the word's tag is full. When the tag is empty it is accepted, writes its data and sets the tag full.
- R4: A synchronizing load is held while the word's tag is empty. When the tag is full it is accepted, returns the stored data and clears the tag to empty.
- R5: The tag command (op code 4) is always accepted. It sets the word's tag to bit 0 of the write data and leaves the data unchanged.
- R6: For each accepted load (op code 0 or 2), rsp_valid of that port is high for exactly one cycle, in the cycle after acceptance, with rsp_data holding the word's value. Other operations produce no response.
- R7: With two ports, a request held on one port does not stop the other port from being accepted at a different address.
- R8: When both ports present requests to the same word and port 0's request is accepted, port 1's ready is low in that cycle. In the next cycle port 1 is checked again against the updated tag.
- R9: Op codes 5 to 7 are accepted at once and have no effect on data, tag or responses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NPORTS | Request valid, one bit per port |
| req_ready | output | NPORTS | Request accepted in this cycle when high together with valid |
| req_op | input | NPORTS x 3 | Operation code per port |
| req_addr | input | NPORTS x ADDR_W | Word address per port |
| req_wdata | input | NPORTS x DATA_W | Store data, or the tag value in bit 0 for op code 4 |
| rsp_valid | output | NPORTS | Load response valid per port |
| rsp_data | output | NPORTS x DATA_W | Load response data per port |

## Verification
The bench builds the block with NPORTS=2, DEPTH=8 and DATA_W=16. Two ports bring the same-word priority path and independent stalling within reach: one port can be parked on an empty word while the other stores, loads and finally fills that word. Eight words are few enough that the reset state of every tag can be probed one by one. Tag state is read at the ports by offering a synchronizing request and sampling ready before the clock edge, so no request is accepted.

// File: rtl/fe_pkg.sv
package fe_pkg;
   localparam int FE_OP_W = 3;
   typedef enum logic [FE_OP_W-1:0] {
      FE_LOAD   = 3'd0,
      FE_STORE  = 3'd1,
      FE_SLOAD  = 3'd2,
      FE_SSTORE = 3'd3,
      FE_TAGSET = 3'd4
   } fe_op_e;
endpackage

// File: rtl/fe_tag_store.sv
module fe_tag_store #(
   parameter int NPORTS = 2,
   parameter int DEPTH  = 16,
   parameter int ADDR_W = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NPORTS-1:0][ADDR_W-1:0] addr,
   input  logic [NPORTS-1:0]             wr_en,
   input  logic [NPORTS-1:0]             wr_val,
   output logic [NPORTS-1:0]             tag_out
);
   logic [DEPTH-1:0] tags;

   always_comb begin
      for (int p = 0; p < NPORTS; p++) begin
         tag_out[p] = tags[addr[p]];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tags <= '0;
      end else begin
         for (int p = 0; p < NPORTS; p++) begin
            if (wr_en[p]) tags[addr[p]] <= wr_val[p];
         end
      end
   end
endmodule

// File: rtl/fe_grant.sv
module fe_grant
   import fe_pkg::*;
#(
   parameter int NPORTS = 2,
   parameter int ADDR_W = 4
) (
   input  logic [NPORTS-1:0]              valid,
   input  logic [NPORTS-1:0][FE_OP_W-1:0] op,
   input  logic [NPORTS-1:0][ADDR_W-1:0]  addr,
   input  logic [NPORTS-1:0]              tag,
   input  logic [NPORTS-1:0]              set_bit,
   output logic [NPORTS-1:0]              ready,
   output logic [NPORTS-1:0]              tag_we,
   output logic [NPORTS-1:0]              tag_val,
   output logic [NPORTS-1:0]              data_we,
   output logic [NPORTS-1:0]              data_re
);
   logic [NPORTS-1:0] eligible;
   logic [NPORTS-1:0] blocked;
   logic [NPORTS-1:0] fire;

   always_comb begin
      for (int p = 0; p < NPORTS; p++) begin
         case (op[p])
            FE_SLOAD:  eligible[p] = tag[p];
            FE_SSTORE: eligible[p] = !tag[p];
            default:   eligible[p] = 1'b1;
         endcase
      end
   end

   generate
      if (NPORTS == 2) begin : g_dual
         assign blocked[0] = 1'b0;
         assign blocked[1] = valid[0] && eligible[0] && (addr[0] == addr[1]);
      end else begin : g_single
         assign blocked = '0;
      end
   endgenerate

   assign ready = eligible & ~blocked;
   assign fire  = ready & valid;

   always_comb begin
      for (int p = 0; p < NPORTS; p++) begin
         tag_we[p]  = 1'b0;
         tag_val[p] = 1'b0;
         data_we[p] = 1'b0;
         data_re[p] = 1'b0;
         if (fire[p]) begin
            case (op[p])
               FE_LOAD:   data_re[p] = 1'b1;
               FE_STORE:  data_we[p] = 1'b1;
               FE_SLOAD:  begin data_re[p] = 1'b1; tag_we[p] = 1'b1; tag_val[p] = 1'b0; end
               FE_SSTORE: begin data_we[p] = 1'b1; tag_we[p] = 1'b1; tag_val[p] = 1'b1; end
               FE_TAGSET: begin tag_we[p] = 1'b1; tag_val[p] = set_bit[p]; end
               default:   ;
            endcase
         end
      end
   end
endmodule

// File: rtl/fe_word_store.sv
module fe_word_store #(
   parameter int NPORTS = 2,
   parameter int DEPTH  = 16,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NPORTS-1:0][ADDR_W-1:0] addr,
   input  logic [NPORTS-1:0]             we,
   input  logic [NPORTS-1:0][DATA_W-1:0] wdata,
   input  logic [NPORTS-1:0]             re,
   output logic [NPORTS-1:0]             rsp_valid,
   output logic [NPORTS-1:0][DATA_W-1:0] rsp_data
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      for (int p = 0; p < NPORTS; p++) begin
         if (we[p]) mem[addr[p]] <= wdata[p];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= '0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= re;
         for (int p = 0; p < NPORTS; p++) begin
            if (re[p]) rsp_data[p] <= mem[addr[p]];
         end
      end
   end
endmodule

// File: rtl/fe_sync_mem.sv
module fe_sync_mem
   import fe_pkg::*;
#(
   parameter int NPORTS = 2,
   parameter int DEPTH  = 16,
   parameter int DATA_W = 32,
   localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NPORTS-1:0]             req_valid,
   output logic [NPORTS-1:0]             req_ready,
   input  logic [NPORTS-1:0][FE_OP_W-1:0] req_op,
   input  logic [NPORTS-1:0][ADDR_W-1:0] req_addr,
   input  logic [NPORTS-1:0][DATA_W-1:0] req_wdata,
   output logic [NPORTS-1:0]             rsp_valid,
   output logic [NPORTS-1:0][DATA_W-1:0] rsp_data
);
   generate
      if (NPORTS < 1 || NPORTS > 2) begin : g_bad_ports
         $error("fe_sync_mem: NPORTS must be 1 or 2");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("fe_sync_mem: DEPTH must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("fe_sync_mem: DATA_W must be positive");
      end
   endgenerate

   logic [NPORTS-1:0] tag_cur;
   logic [NPORTS-1:0] tag_we;
   logic [NPORTS-1:0] tag_val;
   logic [NPORTS-1:0] data_we;
   logic [NPORTS-1:0] data_re;
   logic [NPORTS-1:0] set_bit;

   always_comb begin
      for (int p = 0; p < NPORTS; p++) set_bit[p] = req_wdata[p][0];
   end

   fe_tag_store #(.NPORTS(NPORTS), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_tags (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr    (req_addr),
      .wr_en   (tag_we),
      .wr_val  (tag_val),
      .tag_out (tag_cur)
   );

   fe_grant #(.NPORTS(NPORTS), .ADDR_W(ADDR_W)) u_grant (
      .valid   (req_valid),
      .op      (req_op),
      .addr    (req_addr),
      .tag     (tag_cur),
      .set_bit (set_bit),
      .ready   (req_ready),
      .tag_we  (tag_we),
      .tag_val (tag_val),
      .data_we (data_we),
      .data_re (data_re)
   );

   fe_word_store #(.NPORTS(NPORTS), .DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_words (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr      (req_addr),
      .we        (data_we),
      .wdata     (req_wdata),
      .re        (data_re),
      .rsp_valid (rsp_valid),
      .rsp_data  (rsp_data)
   );
endmodule

// File: rtl/fe_sync_mem_chk.sv
module fe_sync_mem_chk #(
   parameter int NPORTS = 2,
   parameter int DEPTH  = 16,
   parameter int DATA_W = 32,
   localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic [NPORTS-1:0]             req_valid,
   input logic [NPORTS-1:0]             req_ready,
   input logic [NPORTS-1:0][2:0]        req_op,
   input logic [NPORTS-1:0][ADDR_W-1:0] req_addr,
   input logic [NPORTS-1:0][DATA_W-1:0] req_wdata,
   input logic [NPORTS-1:0]             rsp_valid,
   input logic [NPORTS-1:0][DATA_W-1:0] rsp_data
);
   // Tag model rebuilt from accepted requests only.
   logic [DEPTH-1:0]  shadow;
   logic [NPORTS-1:0] acc;
   logic [NPORTS-1:0] is_load;
   logic [NPORTS-1:0] plain;
   logic [NPORTS-1:0] lost_pri;

   always_comb begin
      for (int p = 0; p < NPORTS; p++) begin
         acc[p]     = req_valid[p] && req_ready[p];
         is_load[p] = (req_op[p] == 3'd0) || (req_op[p] == 3'd2);
         plain[p]   = (req_op[p] != 3'd2) && (req_op[p] != 3'd3);
         lost_pri[p] = (p > 0) && acc[0] && (req_addr[0] == req_addr[p]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shadow <= '0;
      end else begin
         for (int p = 0; p < NPORTS; p++) begin
            if (acc[p]) begin
               if (req_op[p] == 3'd2) shadow[req_addr[p]] <= 1'b0;
               if (req_op[p] == 3'd3) shadow[req_addr[p]] <= 1'b1;
               if (req_op[p] == 3'd4) shadow[req_addr[p]] <= req_wdata[p][0];
            end
         end
      end
   end

   generate
      for (genvar p = 0; p < NPORTS; p++) begin : g_port
         // R3
         a_r3_sstore_only_empty: assert property (@(posedge clk) disable iff (!rst_n)
            (acc[p] && req_op[p] == 3'd3) |-> !shadow[req_addr[p]]);
         // R4
         a_r4_sload_only_full: assert property (@(posedge clk) disable iff (!rst_n)
            (acc[p] && req_op[p] == 3'd2) |-> shadow[req_addr[p]]);
         // R6
         a_r6_rsp_after_load: assert property (@(posedge clk) disable iff (!rst_n)
            (acc[p] && is_load[p]) |=> rsp_valid[p]);
         // R6
         a_r6_no_stray_rsp: assert property (@(posedge clk) disable iff (!rst_n)
            !(acc[p] && is_load[p]) |=> !rsp_valid[p]);
         // R2, R5, R9
         a_r2_plain_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[p] && plain[p] && !lost_pri[p]) |-> req_ready[p]);
      end
      if (NPORTS == 2) begin : g_pair
         // R8
         a_r8_one_winner_per_word: assert property (@(posedge clk) disable iff (!rst_n)
            (acc[0] && acc[1]) |-> (req_addr[0] != req_addr[1]));
      end
   endgenerate
endmodule

bind fe_sync_mem fe_sync_mem_chk #(.NPORTS(NPORTS), .DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_fe_sync_mem.sv
`timescale 1ns/1ps
module sim_fe_sync_mem;
   localparam int NP = 2;
   localparam int DP = 8;
   localparam int DW = 16;
   localparam int AW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NP-1:0]          req_valid = '0;
   logic [NP-1:0]          req_ready;
   logic [NP-1:0][2:0]     req_op = '0;
   logic [NP-1:0][AW-1:0]  req_addr = '0;
   logic [NP-1:0][DW-1:0]  req_wdata = '0;
   logic [NP-1:0]          rsp_valid;
   logic [NP-1:0][DW-1:0]  rsp_data;

   int checks = 0;
   int errors = 0;
   logic [DW-1:0] exp_q0[$];
   logic [DW-1:0] exp_q1[$];

   always #2 clk = ~clk;

   fe_sync_mem #(.NPORTS(NP), .DEPTH(DP), .DATA_W(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   // Offer a request for one cycle phase and read ready without letting it be accepted.
   task automatic probe(input int p, input logic [2:0] op, input logic [AW-1:0] a,
                        input logic expr, input string req);
      @(negedge clk);
      req_op[p] = op; req_addr[p] = a; req_wdata[p] = '0; req_valid[p] = 1'b1;
      #1;
      chk(req_ready[p] == expr, req, req_ready[p], expr);
      req_valid[p] = 1'b0;
   endtask

   // Driver: pushes the expected load result, waits for acceptance.
   task automatic issue(input int p, input logic [2:0] op, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input logic [DW-1:0] expd);
      bit ld;
      ld = (op == 3'd0) || (op == 3'd2);
      @(negedge clk);
      req_op[p] = op; req_addr[p] = a; req_wdata[p] = d; req_valid[p] = 1'b1;
      if (ld) begin
         if (p == 0) exp_q0.push_back(expd); else exp_q1.push_back(expd);
      end
      #1;
      while (!req_ready[p]) begin
         @(negedge clk);
         #1;
      end
      @(posedge clk);
      @(negedge clk);
      req_valid[p] = 1'b0;
      chk(rsp_valid[p] == ld, "R6 response flag", rsp_valid[p], ld);
   endtask

   // Monitor: pops the scoreboard whenever a response appears.
   always @(negedge clk) begin
      if (rst_n) begin
         for (int p = 0; p < NP; p++) begin
            if (rsp_valid[p]) begin
               logic [DW-1:0] e;
               if ((p == 0 && exp_q0.size() == 0) || (p == 1 && exp_q1.size() == 0)) begin
                  chk(1'b0, "R6 unexpected response", rsp_data[p], 0);
               end else begin
                  e = (p == 0) ? exp_q0.pop_front() : exp_q1.pop_front();
                  chk(rsp_data[p] == e, "R2/R4/R6 response data", rsp_data[p], e);
               end
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      chk(1'b0, "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: tags start empty everywhere
      chk(rsp_valid == '0, "R1 no response after reset", rsp_valid, 0);
      for (int a = 0; a < DP; a++) probe(0, 3'd2, AW'(a), 1'b0, "R1 sync load held");
      probe(1, 3'd3, 3'd0, 1'b1, "R1 sync store ready");

      // R2: plain store/load leave tag alone
      issue(0, 3'd1, 3'd1, 16'hABCD, '0);
      probe(0, 3'd2, 3'd1, 1'b0, "R2 tag still empty after plain store");
      issue(0, 3'd0, 3'd1, '0, 16'hABCD);

      // R5 then R2 on a full word
      issue(1, 3'd4, 3'd2, 16'h0001, '0);
      probe(1, 3'd3, 3'd2, 1'b0, "R5 tag forced full");
      issue(1, 3'd1, 3'd2, 16'h7777, '0);
      probe(1, 3'd3, 3'd2, 1'b0, "R2 tag still full after plain store");
      issue(1, 3'd0, 3'd2, '0, 16'h7777);
      issue(1, 3'd4, 3'd2, 16'h0000, '0);
      probe(1, 3'd3, 3'd2, 1'b1, "R5 tag forced empty");
      issue(1, 3'd0, 3'd2, '0, 16'h7777);   // R5 data unchanged

      // R3/R4 mailbox cycle
      issue(0, 3'd3, 3'd4, 16'h4444, '0);
      probe(0, 3'd3, 3'd4, 1'b0, "R3 sync store held while full");
      probe(1, 3'd2, 3'd4, 1'b1, "R3 tag set full");
      issue(1, 3'd2, 3'd4, '0, 16'h4444);
      probe(0, 3'd2, 3'd4, 1'b0, "R4 tag cleared by sync load");

      // R9: reserved op has no effect
      probe(0, 3'd6, 3'd4, 1'b1, "R9 reserved op ready");
      issue(0, 3'd6, 3'd4, 16'hFFFF, '0);
      probe(0, 3'd2, 3'd4, 1'b0, "R9 tag unchanged");
      issue(0, 3'd0, 3'd4, '0, 16'h4444);

      // R7: port 0 parked on an empty word, port 1 keeps working
      @(negedge clk);
      req_op[0] = 3'd2; req_addr[0] = 3'd5; req_wdata[0] = '0; req_valid[0] = 1'b1;
      exp_q0.push_back(16'h5555);
      #1;
      chk(req_ready[0] == 1'b0, "R7 port 0 waits", req_ready[0], 0);
      issue(1, 3'd1, 3'd6, 16'h6666, '0);
      issue(1, 3'd0, 3'd6, '0, 16'h6666);
      #1;
      chk(req_ready[0] == 1'b0, "R7 port 0 still waits", req_ready[0], 0);
      issue(1, 3'd3, 3'd5, 16'h5555, '0);
      #1;
      chk(req_ready[0] == 1'b1, "R7 port 0 released", req_ready[0], 1);
      @(posedge clk);
      @(negedge clk);
      req_valid[0] = 1'b0;
      chk(rsp_valid[0] == 1'b1, "R7 port 0 response", rsp_valid[0], 1);

      // R8: same-word collisions
      @(negedge clk);
      req_op[0] = 3'd3; req_addr[0] = 3'd3; req_wdata[0] = 16'h1111; req_valid[0] = 1'b1;
      req_op[1] = 3'd3; req_addr[1] = 3'd3; req_wdata[1] = 16'h2222; req_valid[1] = 1'b1;
      #1;
      chk(req_ready[0] == 1'b1, "R8 port 0 wins", req_ready[0], 1);
      chk(req_ready[1] == 1'b0, "R8 port 1 held", req_ready[1], 0);
      @(negedge clk);
      req_valid[0] = 1'b0;
      #1;
      chk(req_ready[1] == 1'b0, "R8 port 1 sees full tag", req_ready[1], 0);
      @(negedge clk);
      req_op[0] = 3'd2; req_addr[0] = 3'd3; req_valid[0] = 1'b1;
      exp_q0.push_back(16'h1111);
      #1;
      chk(req_ready[0] == 1'b1, "R8 port 0 sync load wins", req_ready[0], 1);
      chk(req_ready[1] == 1'b0, "R8 port 1 held by priority", req_ready[1], 0);
      @(negedge clk);
      req_valid[0] = 1'b0;
      #1;
      chk(req_ready[1] == 1'b1, "R8 port 1 re-evaluated", req_ready[1], 1);
      @(negedge clk);
      req_valid[1] = 1'b0;
      issue(0, 3'd2, 3'd3, '0, 16'h2222);

      repeat (3) @(negedge clk);
      chk(exp_q0.size() == 0 && exp_q1.size() == 0, "R6 all responses seen",
          exp_q0.size() + exp_q1.size(), 0);
      finish_run();
   end
endmodule